// File: doc/BRIEF.md
# Stalled-Rotor Detector with Latched Fault

This block watches the filtered three-bit Hall code of a brushless motor and decides when the rotor has stopped turning. It counts ticks of an external timebase. It declares a stall in two cases. The first is a Hall code that does not change for one lock window. The second is a rotor that only rocks back and forth between the same two codes for one lock window. On a stall it sets a latched fault, which the drive stage uses to switch its gate outputs off.

The fault is cleared in four ways: a power-up or undervoltage reset, either edge of the direction input, the PWM input staying low for more than half a lock window, or the detector being switched off. Detection is suspended while the brake input is high. A window in which PWM never went high does not count as a stall; it restarts instead. The analog oscillator that produces the timebase is outside this block. The tick arrives as a one-cycle pulse synchronous to `clk`.

Top module: `rotor_lock_guard`

## Requirements
- R1: After reset (`rst_n` low), `lock_fault_o` is 0. Asserting reset while the fault is set clears it.
- R2: With detection enabled, brake low and PWM high, `lock_fault_o` rises after `LOCK_TICKS` ticks (default 127) with no change of `hall_i`. The fault is registered on the clock edge that samples the last tick.
- R3: A change of `hall_i` back to the code it held before its previous change is not progress. Toggling between two codes locks `LOCK_TICKS` ticks after the last change to a third, different code.
- R4: A Hall code that keeps stepping through three or more distinct codes, with fewer than `LOCK_TICKS` ticks between steps, never sets the fault.
- R5: Once set, the fault stays set while no clear condition occurs, even if Hall changes and ticks resume.
- R6: Any rising or falling edge of `dir_i` clears the fault on the next clock edge.
- R7: A `pwm_i` low phase that spans `LOCK_TICKS/2+1` ticks (4 when `LOCK_TICKS`=7) clears the fault one clock after that tick. A low phase one tick shorter leaves the fault set.
- R8: While `brake_i` is high, no fault can be set and both windows are held at zero. A brake does not clear a fault that is already set. A full new window is needed after brake is released.
- R9: A lock window during which `pwm_i` was never high ends without a fault and starts a fresh window. The stall is then declared `LOCK_TICKS` ticks after that restart.
- R10: `det_en_i` low clears the fault and blocks detection. After it returns high, a full window is needed before a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up / undervoltage reset, asynchronous |
| tick_i | input | 1 | One-cycle timebase pulse that advances the lock windows |
| hall_i | input | HALL_W | Filtered Hall code |
| dir_i | input | 1 | Direction input; either edge clears the fault |
| pwm_i | input | 1 | PWM command; a long low phase clears the fault |
| brake_i | input | 1 | Brake active; suspends detection |
| det_en_i | input | 1 | Detection enable; low switches detection off and clears the fault |
| lock_fault_o | output | 1 | Latched stall fault; high disables the drive |

## Verification
The hardest case to reach from the ports is the rocking rotor. The Hall code keeps changing, so the simple no-change window is restarted again and again. Only the window that tracks the last two distinct codes expires. The bench first steps to a third code, then toggles back and forth with a fixed number of ticks between flips. It checks that the fault is still low one tick before the window ends and high on the last tick. A similar difficulty applies to the PWM-low window: a window with no PWM high must be shown to restart without a fault. The bench proves the restart by counting how many ticks it takes to lock once PWM returns high.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

   // Ticks of continuous PWM-low needed to exceed half a lock window.
   function automatic int clr_ticks(input int lock_ticks);
      return lock_ticks / 2 + 1;
   endfunction

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/rlg_hall_track.sv
// Remembers the present Hall code and the distinct code before it.
module rlg_hall_track #(
   parameter int HALL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALL_W-1:0] hall_i,
   output logic              any_chg_o,
   output logic              progress_o
);
   logic [HALL_W-1:0] cur_q;
   logic [HALL_W-1:0] alt_q;
   logic              alt_vld_q;
   logic              back_step;

   always_comb begin
      any_chg_o  = (hall_i != cur_q);
      back_step  = alt_vld_q && (hall_i == alt_q);
      progress_o = any_chg_o && !back_step;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= '0;
         alt_q     <= '0;
         alt_vld_q <= 1'b0;
      end else if (any_chg_o) begin
         alt_q     <= cur_q;
         alt_vld_q <= 1'b1;
         cur_q     <= hall_i;
      end
   end
endmodule

// File: rtl/rlg_window.sv
// Tick-counted lock window; expires only if PWM was seen high inside it.
module rlg_window #(
   parameter int LOCK_TICKS = 127
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic restart_i,
   input  logic tick_i,
   input  logic pwm_i,
   output logic expire_o
);
   import rlg_pkg::*;
   localparam int CNT_W = cnt_width(LOCK_TICKS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             seen_q;
   logic             at_end;

   always_comb begin
      at_end   = !hold_i && !restart_i && tick_i && (cnt_q == LAST);
      expire_o = at_end && (seen_q || pwm_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (hold_i) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (restart_i || at_end) begin
         cnt_q  <= '0;
         seen_q <= pwm_i;
      end else begin
         if (tick_i) cnt_q <= cnt_q + 1'b1;
         seen_q <= seen_q || pwm_i;
      end
   end
endmodule

// File: rtl/rlg_pwm_clear.sv
// Counts ticks of an unbroken PWM-low phase; level output once the limit is met.
module rlg_pwm_clear #(
   parameter int CLR_TICKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic pwm_i,
   output logic clr_o
);
   import rlg_pkg::*;
   localparam int CNT_W = cnt_width(CLR_TICKS);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CLR_TICKS);

   logic [CNT_W-1:0] low_cnt_q;

   assign clr_o = (low_cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   low_cnt_q <= '0;
      else if (pwm_i)               low_cnt_q <= '0;
      else if (tick_i && !clr_o)    low_cnt_q <= low_cnt_q + 1'b1;
   end
endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard #(
   parameter int HALL_W     = 3,
   parameter int LOCK_TICKS = 127,
   parameter bit OSC_CHECK  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [HALL_W-1:0] hall_i,
   input  logic              dir_i,
   input  logic              pwm_i,
   input  logic              brake_i,
   input  logic              det_en_i,
   output logic              lock_fault_o
);
   import rlg_pkg::*;
   localparam int CLR_TICKS = clr_ticks(LOCK_TICKS);

   initial begin
      if (LOCK_TICKS < 4) $error("LOCK_TICKS must be at least 4");
      if (HALL_W < 2)     $error("HALL_W must be at least 2");
   end

   logic any_chg, progress;
   logic hold, exp_stall, exp_osc, pwm_clr;
   logic dir_q, dir_edge, lock_hit, clear;
   logic fault_q;

   rlg_hall_track #(.HALL_W(HALL_W)) u_track (
      .clk(clk), .rst_n(rst_n), .hall_i(hall_i),
      .any_chg_o(any_chg), .progress_o(progress)
   );

   assign hold = brake_i || !det_en_i || fault_q;

   rlg_window #(.LOCK_TICKS(LOCK_TICKS)) u_stall (
      .clk(clk), .rst_n(rst_n), .hold_i(hold), .restart_i(any_chg),
      .tick_i(tick_i), .pwm_i(pwm_i), .expire_o(exp_stall)
   );

   generate
      if (OSC_CHECK) begin : g_osc
         rlg_window #(.LOCK_TICKS(LOCK_TICKS)) u_osc (
            .clk(clk), .rst_n(rst_n), .hold_i(hold), .restart_i(progress),
            .tick_i(tick_i), .pwm_i(pwm_i), .expire_o(exp_osc)
         );
      end else begin : g_no_osc
         assign exp_osc = 1'b0;
      end
   endgenerate

   rlg_pwm_clear #(.CLR_TICKS(CLR_TICKS)) u_pclr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pwm_i(pwm_i), .clr_o(pwm_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= 1'b0;
      else        dir_q <= dir_i;
   end

   always_comb begin
      dir_edge = (dir_i != dir_q);
      lock_hit = exp_stall || exp_osc;
      clear    = !det_en_i || dir_edge || pwm_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fault_q <= 1'b0;
      else if (clear)    fault_q <= 1'b0;
      else if (lock_hit) fault_q <= 1'b1;
   end

   assign lock_fault_o = fault_q;
endmodule

// File: rtl/rotor_lock_guard_chk.sv
module rotor_lock_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_i,
   input logic dir_i,
   input logic pwm_i,
   input logic brake_i,
   input logic det_en_i,
   input logic lock_fault_o
);
   // R2: a fault only appears right after a tick with detection active
   p_set_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_fault_o) |-> $past(tick_i && !brake_i && det_en_i));

   // R5: fault holds while no clear condition is present
   p_fault_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_fault_o && det_en_i && pwm_i && $past(pwm_i) && $stable(dir_i))
      |=> lock_fault_o);

   // R6: a direction edge clears the fault
   p_dir_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_i != $past(dir_i)) |=> !lock_fault_o);

   // R8: brake prevents a new fault
   p_brake_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (brake_i && !lock_fault_o) |=> !lock_fault_o);

   // R10: disabling detection clears the fault
   p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en_i |=> !lock_fault_o);
endmodule

bind rotor_lock_guard rotor_lock_guard_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dir_i(dir_i), .pwm_i(pwm_i),
   .brake_i(brake_i), .det_en_i(det_en_i), .lock_fault_o(lock_fault_o)
);

// File: tb/sim_rotor_lock_guard.sv
module sim_rotor_lock_guard;
   localparam int LOCK = 7;
   localparam int CLR  = LOCK / 2 + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] hall = 3'b101;
   logic       dir = 1'b1;
   logic       pwm = 1'b1;
   logic       brake = 1'b0;
   logic       en = 1'b1;
   logic       fault;

   int n_run = 0;
   int n_fail = 0;
   int pos = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rotor_lock_guard #(.HALL_W(3), .LOCK_TICKS(LOCK), .OSC_CHECK(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .hall_i(hall), .dir_i(dir),
      .pwm_i(pwm), .brake_i(brake), .det_en_i(en), .lock_fault_o(fault)
   );

   // forward commutation order of Hall codes
   function automatic logic [2:0] code_at(input int i);
      case (i % 6)
         0: return 3'b101;
         1: return 3'b100;
         2: return 3'b110;
         3: return 3'b010;
         4: return 3'b011;
         default: return 3'b001;
      endcase
   endfunction

   task automatic chk(input string req, input logic exp);
      n_run++;
      if (fault !== exp) begin
         n_fail++;
         $display("FAIL %s: lock_fault_o=%b expected %b", req, fault, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic step_hall(input int p);
      @(negedge clk) hall = code_at(p);
      @(negedge clk);
   endtask

   task automatic settle;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk("R1 reset state", 1'b0);

      // R2: plain no-change stall
      pos = 1; step_hall(pos);
      ticks(LOCK - 1); chk("R2 one tick before window end", 1'b0);
      ticks(1);        chk("R2 stall declared", 1'b1);

      // R5: latched despite new Hall activity
      pos = 2; step_hall(pos);
      ticks(3 * LOCK); chk("R5 fault stays latched", 1'b1);

      // R6: falling DIR edge clears
      @(negedge clk) dir = 1'b0;
      settle();        chk("R6 falling dir edge clears", 1'b0);

      // R4: steady rotation never locks
      for (int s = 0; s < 18; s++) begin
         pos++; step_hall(pos);
         ticks(LOCK - 2);
         if (s % 6 == 5) chk("R4 rotating motor stays unlocked", 1'b0);
      end

      // R3: rocking between two codes
      pos++; step_hall(pos);
      for (int k = 0; k < 3; k++) begin
         ticks(2);
         step_hall((k % 2 == 0) ? pos - 1 : pos);
      end
      chk("R3 no lock before window end while rocking", 1'b0);
      ticks(1);
      chk("R3 rocking rotor locks", 1'b1);

      // R7: long PWM-low clears, shorter does not
      @(negedge clk) pwm = 1'b0;
      ticks(CLR - 1);  chk("R7 short pwm low keeps fault", 1'b1);
      ticks(1);        chk("R7 long pwm low clears", 1'b0);

      // R9: window without PWM high restarts
      ticks(LOCK + 3); chk("R9 no lock with pwm low all window", 1'b0);
      @(negedge clk) pwm = 1'b1;
      @(negedge clk);
      ticks(LOCK - 4); chk("R9 restarted window not yet done", 1'b0);
      ticks(1);        chk("R9 lock after restarted window", 1'b1);

      // R8: brake
      @(negedge clk) brake = 1'b1;
      ticks(3);        chk("R8 brake does not clear fault", 1'b1);
      @(negedge clk) dir = 1'b1;
      settle();        chk("R6 rising dir edge clears", 1'b0);
      ticks(3 * LOCK); chk("R8 no lock while braking", 1'b0);
      @(negedge clk) brake = 1'b0;
      @(negedge clk);
      ticks(LOCK - 1); chk("R8 full window needed after brake", 1'b0);
      ticks(1);        chk("R8 lock after brake release", 1'b1);

      // R10: detection enable
      @(negedge clk) en = 1'b0;
      settle();        chk("R10 disable clears fault", 1'b0);
      ticks(3 * LOCK); chk("R10 no lock while disabled", 1'b0);
      @(negedge clk) en = 1'b1;
      @(negedge clk);
      ticks(LOCK - 1); chk("R10 full window after enable", 1'b0);
      ticks(1);        chk("R10 lock after enable", 1'b1);

      // R1: reset clears a latched fault
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);  chk("R1 reset clears fault", 1'b0);
      rst_n = 1'b1;
      settle();        chk("R1 fault low after reset release", 1'b0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         repeat (100000) @(posedge clk);
      join_any
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run incomplete, expected completion");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule